// File: doc/BRIEF.md
# Configurable Logic Cell

The block models one cell of a programmable logic fabric. A lookup table turns the cell's data inputs into any Boolean function of them. An optional adder slice can replace the table result, and an optional cascade gate can merge it with the result of a neighbouring cell. The outcome leaves the cell either directly or through a storage element. That element can act as a D, T, JK or SR flip-flop.

The storage element takes its clock and its clear/preset from four control lines that a cluster of cells shares. Any of these lines can be inverted before use. All configuration enters on static ports and is captured while reset is held. A fabric clock `clk` samples the selected clock line and detects its rising edge. Clear and preset act on the cell output in the same cycle they are asserted, with no clock edge needed.

Top module: `plc_cell`

## Requirements
- R1: With `cfg_registered`=0 and `cfg_carry`=0 and `cfg_casc_en`=0, `le_out` equals bit `data` of the table word, where `data[3]` is the most significant index bit.
- R2: With `cfg_registered`=0, `le_out` follows `data` at once, and toggling any `ctl` line leaves it unchanged.
- R3: After reset the stored state is 0. In kind 0 (D), a rising edge of the selected clock line loads the function result, and with no edge the state holds.
- R4: In kind 1 (T), a clock edge inverts the state when the function result is 1 and keeps it when the result is 0.
- R5: In kind 2 (JK), with J=`data[0]` and K=`data[1]`, a clock edge acts as follows: J alone sets, K alone clears, both toggle, neither holds.
- R6: In kind 3 (SR), with S=`data[0]` and R=`data[1]`, a clock edge acts as follows: S alone sets, R alone clears, both or neither hold.
- R7: The clock line is `ctl[0]` when `cfg_clk_sel`=0 and `ctl[1]` when it is 1. Bit i of `cfg_inv` inverts `ctl[i]`, so an inverted line clocks on the falling edge of the pin. The unselected line has no effect.
- R8: Clear and preset are active low after inversion. Clear uses `ctl[2]` when `cfg_clr_sel`=0 and `ctl[3]` when it is 1, and is gated by `cfg_clr_en`. Preset selects its line the same way through `cfg_pre_sel` and is gated by `cfg_pre_en`. Either one forces `le_out` in the same cycle and sets the stored state. Clear wins when both are asserted.
- R9: With `cfg_carry`=1, the function result is `data[0]`^`data[1]`^`carry_in` and `carry_out` is the majority of those three. With `cfg_carry`=0, `carry_out` is 0.
- R10: With `cfg_casc_en`=1, the function result is the base result ANDed with `cascade_in`, or ORed with it when `cfg_casc_or`=1. `cascade_out` always carries the function result.
- R11: Configuration ports are sampled only while `rst_n` is low. Later changes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples the control lines |
| rst_n | input | 1 | Active-low synchronous reset; configuration is captured while it is low |
| data | input | K | Cell data inputs |
| ctl | input | 4 | Shared cluster control lines |
| carry_in | input | 1 | Carry from the previous cell |
| cascade_in | input | 1 | Cascade result from the previous cell |
| cfg_lut | input | 2**K | Lookup table contents |
| cfg_inv | input | 4 | Per-line inversion of `ctl` |
| cfg_registered | input | 1 | 1: output through storage element; 0: bypass |
| cfg_ff_kind | input | 2 | Storage behaviour: 0 D, 1 T, 2 JK, 3 SR |
| cfg_clk_sel | input | 1 | Clock line select |
| cfg_clr_en | input | 1 | Clear enable |
| cfg_clr_sel | input | 1 | Clear line select |
| cfg_pre_en | input | 1 | Preset enable |
| cfg_pre_sel | input | 1 | Preset line select |
| cfg_carry | input | 1 | Adder slice mode |
| cfg_casc_en | input | 1 | Cascade gate enable |
| cfg_casc_or | input | 1 | Cascade gate: 1 OR, 0 AND |
| le_out | output | 1 | Cell output |
| carry_out | output | 1 | Carry to the next cell |
| cascade_out | output | 1 | Function result to the next cell |

## Verification
The bench builds the cell with the default K=4, so the full 16-entry table can be walked exhaustively. The JK and SR inputs also map onto the two lowest data bits, as in the adder slice. At this size all eight adder input combinations and every two-input code of each flip-flop kind take only a few cycles. This leaves room to repeat the storage tests with inverted and reselected clock and clear/preset lines.

// File: rtl/plc_cell.sv
module plc_cell #(
  parameter int K = 4,
  localparam int LW = 1 << K
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [K-1:0]  data,
  input  logic [3:0]    ctl,
  input  logic          carry_in,
  input  logic          cascade_in,
  input  logic [LW-1:0] cfg_lut,
  input  logic [3:0]    cfg_inv,
  input  logic          cfg_registered,
  input  logic [1:0]    cfg_ff_kind,
  input  logic          cfg_clk_sel,
  input  logic          cfg_clr_en,
  input  logic          cfg_clr_sel,
  input  logic          cfg_pre_en,
  input  logic          cfg_pre_sel,
  input  logic          cfg_carry,
  input  logic          cfg_casc_en,
  input  logic          cfg_casc_or,
  output logic          le_out,
  output logic          carry_out,
  output logic          cascade_out
);

  logic [LW-1:0] r_lut;
  logic [3:0]    r_inv;
  logic          r_registered, r_clk_sel, r_clr_en, r_clr_sel;
  logic          r_pre_en, r_pre_sel, r_carry, r_casc_en, r_casc_or;
  logic [1:0]    r_kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_lut        <= cfg_lut;
      r_inv        <= cfg_inv;
      r_registered <= cfg_registered;
      r_kind       <= cfg_ff_kind;
      r_clk_sel    <= cfg_clk_sel;
      r_clr_en     <= cfg_clr_en;
      r_clr_sel    <= cfg_clr_sel;
      r_pre_en     <= cfg_pre_en;
      r_pre_sel    <= cfg_pre_sel;
      r_carry      <= cfg_carry;
      r_casc_en    <= cfg_casc_en;
      r_casc_or    <= cfg_casc_or;
    end
  end

  logic [3:0] line;
  logic       clk_line, clk_prev, clk_edge, clr_act, pre_act;
  logic       lut_bit, sum, base, f, q, q_next;

  assign line     = ctl ^ r_inv;
  assign clk_line = r_clk_sel ? line[1] : line[0];
  assign clk_edge = clk_line & ~clk_prev;
  assign clr_act  = r_clr_en & ~(r_clr_sel ? line[3] : line[2]);
  assign pre_act  = r_pre_en & ~(r_pre_sel ? line[3] : line[2]);

  assign lut_bit   = r_lut[data];
  assign sum       = data[0] ^ data[1] ^ carry_in;
  assign carry_out = r_carry & ((data[0] & data[1]) | (data[0] & carry_in) | (data[1] & carry_in));
  assign base      = r_carry ? sum : lut_bit;
  assign f         = !r_casc_en ? base : (r_casc_or ? (base | cascade_in) : (base & cascade_in));
  assign cascade_out = f;

  always_comb begin
    q_next = q;
    case (r_kind)
      2'd0: q_next = f;
      2'd1: q_next = q ^ f;
      2'd2: begin
        case ({data[1], data[0]})
          2'b01:   q_next = 1'b1;
          2'b10:   q_next = 1'b0;
          2'b11:   q_next = ~q;
          default: q_next = q;
        endcase
      end
      default: begin
        case ({data[1], data[0]})
          2'b01:   q_next = 1'b1;
          2'b10:   q_next = 1'b0;
          default: q_next = q;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q        <= 1'b0;
      clk_prev <= cfg_clk_sel ? (ctl[1] ^ cfg_inv[1]) : (ctl[0] ^ cfg_inv[0]);
    end else begin
      clk_prev <= clk_line;
      if (clr_act)       q <= 1'b0;
      else if (pre_act)  q <= 1'b1;
      else if (clk_edge) q <= q_next;
    end
  end

  assign le_out = r_registered ? (clr_act ? 1'b0 : (pre_act ? 1'b1 : q)) : f;

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_edge && !clr_act && !pre_act) |=> q == $past(q));

  a_r3_dload: assert property (@(posedge clk) disable iff (!rst_n)
    (r_kind == 2'd0 && clk_edge && !clr_act && !pre_act) |=> q == $past(f));

  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (r_kind == 2'd1 && clk_edge && f && !clr_act && !pre_act) |=> q != $past(q));

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> !q);

  a_r8_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_act && !clr_act) |=> q);

  a_r8_out_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (r_registered && clr_act) |-> !le_out);

endmodule

// File: tb/plc_cell_tb.sv
module plc_cell_tb;
  logic clk = 0, rst_n = 0;
  logic [3:0] data = 0, ctl = 0;
  logic carry_in = 0, cascade_in = 0;
  logic [15:0] cfg_lut = 0;
  logic [3:0] cfg_inv = 0;
  logic cfg_registered = 0, cfg_clk_sel = 0, cfg_clr_en = 0, cfg_clr_sel = 0;
  logic cfg_pre_en = 0, cfg_pre_sel = 0, cfg_carry = 0, cfg_casc_en = 0, cfg_casc_or = 0;
  logic [1:0] cfg_ff_kind = 0;
  logic le_out, carry_out, cascade_out;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  plc_cell #(.K(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .data(data), .ctl(ctl), .carry_in(carry_in),
    .cascade_in(cascade_in), .cfg_lut(cfg_lut), .cfg_inv(cfg_inv),
    .cfg_registered(cfg_registered), .cfg_ff_kind(cfg_ff_kind),
    .cfg_clk_sel(cfg_clk_sel), .cfg_clr_en(cfg_clr_en), .cfg_clr_sel(cfg_clr_sel),
    .cfg_pre_en(cfg_pre_en), .cfg_pre_sel(cfg_pre_sel), .cfg_carry(cfg_carry),
    .cfg_casc_en(cfg_casc_en), .cfg_casc_or(cfg_casc_or),
    .le_out(le_out), .carry_out(carry_out), .cascade_out(cascade_out));

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic defaults();
    cfg_lut = 0; cfg_inv = 0; cfg_registered = 0; cfg_ff_kind = 0; cfg_clk_sel = 0;
    cfg_clr_en = 0; cfg_clr_sel = 0; cfg_pre_en = 0; cfg_pre_sel = 0;
    cfg_carry = 0; cfg_casc_en = 0; cfg_casc_or = 0;
    data = 0; carry_in = 0; cascade_in = 0;
  endtask

  task automatic restart();
    @(negedge clk);
    ctl = {~cfg_inv[3:2], cfg_inv[1:0]};
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse(input int idx);
    ctl[idx] = ~ctl[idx];
    @(negedge clk);
    ctl[idx] = ~ctl[idx];
    @(negedge clk);
  endtask

  task automatic t_reset_lut();
    defaults(); cfg_registered = 1; restart();
    chk(le_out, 1'b0, "R3 reset state");
    defaults(); cfg_lut = 16'hA5C3; restart();
    for (int i = 0; i < 16; i++) begin
      data = 4'(i); #1;
      chk(le_out, cfg_lut[i], "R1 table index");
    end
    data = 4'd2; #1;
    for (int j = 0; j < 4; j++) begin
      ctl[j] = ~ctl[j]; @(negedge clk);
      chk(le_out, cfg_lut[2], "R2 bypass ignores ctl");
    end
  endtask

  task automatic t_dmode();
    defaults(); cfg_registered = 1; cfg_lut = 16'h0002; restart();
    data = 1; pulse(0); chk(le_out, 1'b1, "R3 D load 1");
    data = 0; repeat (3) @(negedge clk); chk(le_out, 1'b1, "R3 D hold");
    pulse(0); chk(le_out, 1'b0, "R3 D load 0");
  endtask

  task automatic t_tmode();
    defaults(); cfg_registered = 1; cfg_ff_kind = 1; cfg_lut = 16'h0002; restart();
    data = 1; pulse(0); chk(le_out, 1'b1, "R4 T toggle up");
    pulse(0); chk(le_out, 1'b0, "R4 T toggle down");
    data = 0; pulse(0); chk(le_out, 1'b0, "R4 T keep");
  endtask

  task automatic t_jk();
    defaults(); cfg_registered = 1; cfg_ff_kind = 2; restart();
    data = 4'b0001; pulse(0); chk(le_out, 1'b1, "R5 JK set");
    data = 4'b0000; pulse(0); chk(le_out, 1'b1, "R5 JK hold");
    data = 4'b0010; pulse(0); chk(le_out, 1'b0, "R5 JK clear");
    data = 4'b0011; pulse(0); chk(le_out, 1'b1, "R5 JK toggle 1");
    pulse(0); chk(le_out, 1'b0, "R5 JK toggle 2");
  endtask

  task automatic t_sr();
    defaults(); cfg_registered = 1; cfg_ff_kind = 3; restart();
    data = 4'b0001; pulse(0); chk(le_out, 1'b1, "R6 SR set");
    data = 4'b0011; pulse(0); chk(le_out, 1'b1, "R6 SR both hold 1");
    data = 4'b0010; pulse(0); chk(le_out, 1'b0, "R6 SR reset");
    data = 4'b0011; pulse(0); chk(le_out, 1'b0, "R6 SR both hold 0");
  endtask

  task automatic t_clksel();
    defaults(); cfg_registered = 1; cfg_lut = 16'hFFFF; cfg_clk_sel = 1; cfg_inv = 4'b0010;
    restart();
    pulse(0); chk(le_out, 1'b0, "R7 unselected line ignored");
    ctl[1] = 0; @(negedge clk); chk(le_out, 1'b1, "R7 inverted line clocks on falling pin");
    ctl[1] = 1; @(negedge clk);
  endtask

  task automatic t_clrpre();
    defaults(); cfg_registered = 1; cfg_lut = 16'h0000;
    cfg_clr_en = 1; cfg_clr_sel = 0; cfg_pre_en = 1; cfg_pre_sel = 1; cfg_inv = 4'b0100;
    restart();
    ctl[3] = 0; #1; chk(le_out, 1'b1, "R8 preset immediate");
    @(negedge clk); ctl[3] = 1; @(negedge clk); chk(le_out, 1'b1, "R8 preset stored");
    ctl[2] = 1; #1; chk(le_out, 1'b0, "R8 inverted clear immediate");
    ctl[3] = 0; @(negedge clk); chk(le_out, 1'b0, "R8 clear wins");
    ctl[2] = 0; ctl[3] = 1; @(negedge clk); chk(le_out, 1'b0, "R8 clear stored");
  endtask

  task automatic t_carry();
    defaults(); cfg_carry = 1; restart();
    for (int i = 0; i < 8; i++) begin
      data = {2'b00, i[1], i[0]}; carry_in = i[2]; #1;
      chk(le_out, i[0] ^ i[1] ^ i[2], "R9 sum");
      chk(carry_out, (i[0] & i[1]) | (i[0] & i[2]) | (i[1] & i[2]), "R9 carry out");
    end
    defaults(); cfg_lut = 16'hFFFF; restart();
    data = 4'b0011; carry_in = 1; #1;
    chk(carry_out, 1'b0, "R9 carry off");
  endtask

  task automatic t_cascade();
    defaults(); cfg_lut = 16'h0002; cfg_casc_en = 1; restart();
    data = 1; cascade_in = 0; #1; chk(le_out, 1'b0, "R10 AND 1&0");
    cascade_in = 1; #1; chk(le_out, 1'b1, "R10 AND 1&1");
    chk(cascade_out, 1'b1, "R10 cascade out");
    data = 0; #1; chk(le_out, 1'b0, "R10 AND 0&1");
    defaults(); cfg_lut = 16'h0002; cfg_casc_en = 1; cfg_casc_or = 1; restart();
    data = 0; cascade_in = 1; #1; chk(le_out, 1'b1, "R10 OR 0|1");
    cascade_in = 0; #1; chk(le_out, 1'b0, "R10 OR 0|0");
    chk(cascade_out, 1'b0, "R10 cascade out low");
  endtask

  task automatic t_cfg_static();
    defaults(); cfg_lut = 16'hFFFF; restart();
    cfg_lut = 16'h0000; cfg_registered = 1; cfg_carry = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      data = 4'(i * 5); #1;
      chk(le_out, 1'b1, "R11 config held");
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_lut();
    t_dmode();
    t_tmode();
    t_jk();
    t_sr();
    t_clksel();
    t_clrpre();
    t_carry();
    t_cascade();
    t_cfg_static();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule